// File: doc/BRIEF.md
# NAND Page Column to Buffer Address Mapper

This block translates a linear column offset within a NAND page, where the main data bytes come first and the spare bytes follow, into an address inside a flash controller's internal buffer memory. The main data lives in one flat region starting at buffer address 0. The spare bytes are split across several small spare buffers, one for each 512-byte chunk of the page, placed at a fixed base address with a fixed stride between buffers.

The share of spare bytes in each buffer is the spare size divided by the number of chunks, rounded down to an even count. The bytes lost to that rounding all go into the last buffer in use. For each request the mapper returns three things: the buffer address, whether the access landed in the main region or a spare buffer, and how many bytes can be moved contiguously before the next buffer boundary. A software copy loop or a DMA sequencer uses that length to split a transfer. The mapper also returns the spare size expressed in 16-bit words, which is the value a controller's spare-size setting expects. A spare-only mode treats the column directly as an offset into the spare area.

All results come out of one register stage, one cycle after a request strobe, and are qualified by a valid strobe.

Top module: `nand_col_mapper`

## Requirements
- R1: After reset `out_valid` is 0 and every result output is 0. A cycle with `in_valid` high produces `out_valid` high in exactly the next cycle. A cycle with `in_valid` low produces `out_valid` low in the next cycle.
- R2: The page-size code `in_page_sel` is encoded as 0 = 512 bytes, 1 = 2048 bytes, 2 = 4096 bytes and 3 = unsupported. When spare-only mode is off and the column is below the page size, the result is a main access: `out_is_spare` = 0, `out_addr` = column, and `out_run_len` = page size − column.
- R3: The spare area is divided into page size / 512 chunks. Each buffer holds (spare size / chunks) with bit 0 cleared, so the per-buffer count is even and rounded down.
- R4: The bytes lost to that rounding are placed in the last used buffer (index chunks − 1). Spare offsets beyond the regular buffers map into that buffer at byte offsets at or above the per-buffer count.
- R5: A spare access maps to buffer index = spare offset / per-buffer count, clamped to chunks − 1, and byte = spare offset − index × per-buffer count. Its address is 0x1000 + index × 0x40 + byte. `out_run_len` is per-buffer count − byte, or spare size − spare offset in the last used buffer.
- R6: When the column is at or above the page size, the spare offset is column − page size. In spare-only mode (`in_spare_only` = 1) the spare offset is the column itself, and the main region is never selected.
- R7: `out_spare_words` equals the requested spare size shifted right by one (the spare size in 16-bit words).
- R8: `out_err` = 1, with `out_addr`, `out_run_len` and `out_is_spare` all 0, in any of these cases: the page code is 3; the per-buffer count is 0; the last buffer would exceed 64 bytes; or a spare offset is at or beyond the spare size.
- R9: While `in_valid` is low, changes on the request inputs leave every result output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_page_sel | input | 2 | Page size code (0=512, 1=2048, 2=4096, 3=unsupported) |
| in_spare_bytes | input | 9 | Spare area size in bytes |
| in_column | input | 13 | Linear column offset within the page |
| in_spare_only | input | 1 | Treat the column as a spare offset |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 13 | Buffer memory byte address |
| out_is_spare | output | 1 | 1 when the access maps to a spare buffer |
| out_run_len | output | 13 | Contiguous bytes up to the next buffer boundary |
| out_err | output | 1 | Unsupported geometry or out-of-range offset |
| out_spare_words | output | 8 | Spare size in 16-bit words |

## Verification
The assertions take for granted that the request inputs are stable over the whole cycle in which `in_valid` is high. The page-span property relies on `$past` of the page code, and it holds only when the result really came from that same cycle's inputs. The bench drives every input on the falling edge, pulses `in_valid` for exactly one cycle, and samples at the next falling edge. It sweeps a set of geometries, from legal ones to ones that overflow the last buffer or give a zero per-buffer count, including odd spare sizes so that the leftover handling is exercised.

// File: rtl/nand_map_pkg.sv
package nand_map_pkg;

    localparam int COL_W   = 13;
    localparam int SPARE_W = 9;
    localparam int ADDR_W  = 13;
    localparam int CHUNK_BYTES_LOG2 = 9;

    typedef enum logic [1:0] {
        PG_512  = 2'd0,
        PG_2K   = 2'd1,
        PG_4K   = 2'd2,
        PG_BAD  = 2'd3
    } page_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic               is_spare;
        logic [COL_W-1:0]   run_len;
        logic               err;
        logic [SPARE_W-2:0] words;
    } map_result_t;

    // log2 of the number of 512-byte chunks in a page
    function automatic logic [1:0] chunk_shift(input page_sel_e sel);
        case (sel)
            PG_2K:   return 2'd2;
            PG_4K:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] page_bytes(input page_sel_e sel);
        if (sel == PG_BAD) return '0;
        return COL_W'(1) << (CHUNK_BYTES_LOG2 + int'(chunk_shift(sel)));
    endfunction

endpackage

// File: rtl/nand_spare_geom.sv
module nand_spare_geom
    import nand_map_pkg::*;
#(
    parameter int NBUF      = 8,
    parameter int BUF_BYTES = 64,
    localparam int IDX_W    = $clog2(NBUF)
) (
    input  page_sel_e            sel,
    input  logic [SPARE_W-1:0]   spare,
    output logic [COL_W-1:0]     pg_bytes,
    output logic [IDX_W-1:0]     last_idx,
    output logic [SPARE_W-1:0]   per_buf,
    output logic [SPARE_W-1:0]   last_size,
    output logic                 cfg_err
);
    localparam int LEAD_W = SPARE_W + 3;

    logic [1:0]        shift;
    logic [3:0]        chunks_m1;
    logic [LEAD_W-1:0] lead_bytes;

    always_comb begin
        shift      = chunk_shift(sel);
        pg_bytes   = page_bytes(sel);
        chunks_m1  = (4'd1 << shift) - 4'd1;
        last_idx   = IDX_W'(chunks_m1);
        per_buf    = (spare >> shift) & ~SPARE_W'(1);
        // bytes held by all buffers before the last one
        lead_bytes = (LEAD_W'(per_buf) << shift) - LEAD_W'(per_buf);
        last_size  = spare - lead_bytes[SPARE_W-1:0];
        cfg_err    = (sel == PG_BAD) || (per_buf == '0)
                   || (int'(last_size) > BUF_BYTES)
                   || (int'(chunks_m1) > NBUF - 1);
    end
endmodule

// File: rtl/nand_spare_locate.sv
module nand_spare_locate
    import nand_map_pkg::*;
#(
    parameter int NBUF      = 8,
    parameter int BUF_BYTES = 64,
    localparam int IDX_W    = $clog2(NBUF),
    localparam int OFF_W    = $clog2(BUF_BYTES)
) (
    input  logic [COL_W-1:0]   soff,
    input  logic [SPARE_W-1:0] per_buf,
    input  logic [IDX_W-1:0]   last_idx,
    input  logic [SPARE_W-1:0] spare,
    output logic [IDX_W-1:0]   idx,
    output logic [OFF_W-1:0]   byte_off,
    output logic [COL_W-1:0]   run_len,
    output logic               range_err
);
    logic [NBUF-1:0]  past_edge;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] off_full;

    // one comparator per buffer boundary: a thermometer code of the index
    assign past_edge[0] = 1'b0;
    for (genvar k = 1; k < NBUF; k++) begin : g_edge
        assign past_edge[k] = (IDX_W'(k) <= last_idx)
                           && (soff >= COL_W'(k) * COL_W'(per_buf));
    end

    always_comb begin
        idx = '0;
        for (int k = 1; k < NBUF; k++) begin
            if (past_edge[k]) idx = idx + IDX_W'(1);
        end
        base      = COL_W'(idx) * COL_W'(per_buf);
        off_full  = soff - base;
        byte_off  = off_full[OFF_W-1:0];
        range_err = soff >= COL_W'(spare);
        if (idx == last_idx) run_len = COL_W'(spare) - soff;
        else                 run_len = COL_W'(per_buf) - off_full;
    end
endmodule

// File: rtl/nand_col_mapper.sv
module nand_col_mapper
    import nand_map_pkg::*;
#(
    parameter int NBUF       = 8,
    parameter int BUF_BYTES  = 64,
    parameter int SPARE_BASE = 'h1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_page_sel,
    input  logic [SPARE_W-1:0] in_spare_bytes,
    input  logic [COL_W-1:0]   in_column,
    input  logic               in_spare_only,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_is_spare,
    output logic [COL_W-1:0]   out_run_len,
    output logic               out_err,
    output logic [SPARE_W-2:0] out_spare_words
);
    localparam int IDX_W = $clog2(NBUF);
    localparam int OFF_W = $clog2(BUF_BYTES);

    page_sel_e          sel;
    logic [COL_W-1:0]   pg_bytes;
    logic [IDX_W-1:0]   last_idx;
    logic [SPARE_W-1:0] per_buf;
    logic [SPARE_W-1:0] last_size;
    logic               cfg_err;
    logic               to_spare;
    logic [COL_W-1:0]   soff;
    logic [IDX_W-1:0]   idx;
    logic [OFF_W-1:0]   byte_off;
    logic [COL_W-1:0]   spare_len;
    logic               range_err;
    map_result_t        nxt, cur;

    assign sel = page_sel_e'(in_page_sel);

    nand_spare_geom #(.NBUF(NBUF), .BUF_BYTES(BUF_BYTES)) u_geom (
        .sel(sel), .spare(in_spare_bytes), .pg_bytes(pg_bytes),
        .last_idx(last_idx), .per_buf(per_buf), .last_size(last_size),
        .cfg_err(cfg_err)
    );

    assign to_spare = in_spare_only || (in_column >= pg_bytes);
    assign soff     = in_spare_only ? in_column : in_column - pg_bytes;

    nand_spare_locate #(.NBUF(NBUF), .BUF_BYTES(BUF_BYTES)) u_loc (
        .soff(soff), .per_buf(per_buf), .last_idx(last_idx),
        .spare(in_spare_bytes), .idx(idx), .byte_off(byte_off),
        .run_len(spare_len), .range_err(range_err)
    );

    always_comb begin
        nxt       = '0;
        nxt.words = in_spare_bytes[SPARE_W-1:1];
        if (cfg_err || (to_spare && range_err)) begin
            nxt.err = 1'b1;
        end else if (to_spare) begin
            nxt.is_spare = 1'b1;
            nxt.addr     = ADDR_W'(SPARE_BASE)
                         + (ADDR_W'(idx) << OFF_W) + ADDR_W'(byte_off);
            nxt.run_len  = spare_len;
        end else begin
            nxt.addr     = ADDR_W'(in_column);
            nxt.run_len  = pg_bytes - in_column;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cur       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) cur <= nxt;
        end
    end

    assign out_addr        = cur.addr;
    assign out_is_spare    = cur.is_spare;
    assign out_run_len     = cur.run_len;
    assign out_err         = cur.err;
    assign out_spare_words = cur.words;
endmodule

// File: rtl/nand_col_mapper_chk.sv
module nand_col_mapper_chk
    import nand_map_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [1:0]         in_page_sel,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  out_addr,
    input logic               out_is_spare,
    input logic [COL_W-1:0]   out_run_len,
    input logic               out_err
);
    // R1: the strobe follows the request by exactly one cycle
    p_strobe_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_strobe_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: a main access runs exactly to the end of the page
    p_main_span_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err && !out_is_spare) |->
        ((out_addr + out_run_len) == page_bytes(page_sel_e'($past(in_page_sel)))));

    // R5: a spare access stays inside one 64-byte buffer window
    p_spare_window_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err && out_is_spare) |->
        (out_addr[12] && (out_run_len != '0)
         && ((COL_W'(out_addr[5:0]) + out_run_len) <= COL_W'(64))));

    // R8: an error result carries no address and no length
    p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |->
        ((out_addr == '0) && (out_run_len == '0) && !out_is_spare));

    // R9: results hold while no request arrives
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_addr) && $stable(out_run_len)
                       && $stable(out_err) && $stable(out_is_spare)));
endmodule

bind nand_col_mapper nand_col_mapper_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_page_sel(in_page_sel),
    .out_valid(out_valid), .out_addr(out_addr), .out_is_spare(out_is_spare),
    .out_run_len(out_run_len), .out_err(out_err)
);

// File: tb/tb_nand_col_mapper.sv
module tb_nand_col_mapper;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_page_sel;
    logic [8:0]  in_spare_bytes;
    logic [12:0] in_column;
    logic        in_spare_only;
    logic        out_valid;
    logic [12:0] out_addr;
    logic        out_is_spare;
    logic [12:0] out_run_len;
    logic        out_err;
    logic [7:0]  out_spare_words;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    nand_col_mapper dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_page_sel(in_page_sel),
        .in_spare_bytes(in_spare_bytes), .in_column(in_column),
        .in_spare_only(in_spare_only), .out_valid(out_valid),
        .out_addr(out_addr), .out_is_spare(out_is_spare),
        .out_run_len(out_run_len), .out_err(out_err),
        .out_spare_words(out_spare_words)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // independent reference model of the mapping
    task automatic model(input int sel, input int spare, input int col, input bit so,
                         output int addr, output int is_sp, output int len, output int err);
        int page, chunks, pb, lastsz, soff, idx, bo;
        page   = (sel == 0) ? 512 : (sel == 1) ? 2048 : (sel == 2) ? 4096 : 0;
        chunks = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 1;
        pb     = (spare / chunks) & ~1;
        lastsz = spare - (chunks - 1) * pb;
        addr = 0; is_sp = 0; len = 0; err = 0;
        if (sel == 3 || pb == 0 || lastsz > 64) begin err = 1; return; end
        if (!so && col < page) begin addr = col; len = page - col; return; end
        soff = so ? col : col - page;
        if (soff >= spare) begin err = 1; return; end
        idx = soff / pb;
        if (idx > chunks - 1) idx = chunks - 1;
        bo   = soff - idx * pb;
        addr = 'h1000 + idx * 'h40 + bo;
        is_sp = 1;
        len  = (idx == chunks - 1) ? spare - soff : pb - bo;
    endtask

    task automatic run_one(input string req, input int sel, input int spare,
                           input int col, input bit so);
        int ea, es, el, ee;
        model(sel, spare, col, so, ea, es, el, ee);
        @(negedge clk);
        in_valid = 1; in_page_sel = 2'(sel); in_spare_bytes = 9'(spare);
        in_column = 13'(col); in_spare_only = so;
        @(negedge clk);
        in_valid = 0;
        check(req, "valid",    int'(out_valid),    1);
        check(req, "err",      int'(out_err),      ee);
        check(req, "is_spare", int'(out_is_spare), es);
        check(req, "addr",     int'(out_addr),     ea);
        check(req, "run_len",  int'(out_run_len),  el);
    endtask

    task automatic t_reset();
        check("R1", "reset valid", int'(out_valid), 0);
        check("R1", "reset addr",  int'(out_addr), 0);
        check("R1", "reset len",   int'(out_run_len), 0);
        check("R1", "reset err",   int'(out_err), 0);
    endtask

    task automatic t_main();
        run_one("R2", 1, 64, 100, 0);
        run_one("R2", 1, 64, 2047, 0);
        run_one("R2", 0, 16, 0, 0);
        run_one("R2", 2, 128, 4000, 0);
    endtask

    task automatic t_chunking();
        run_one("R3", 1, 64, 2048 + 20, 0);   // 0x1044, len 12
        check("R3", "addr literal", int'(out_addr), 'h1044);
        run_one("R3", 1, 66, 2048 + 17, 0);   // per-buffer 16 from 16.5
        run_one("R5", 2, 128, 4096 + 127, 0); // 0x11CF, len 1
        check("R5", "addr literal", int'(out_addr), 'h11CF);
        run_one("R6", 1, 64, 2048, 0);        // first spare byte
    endtask

    task automatic t_leftover();
        run_one("R4", 1, 70, 2048 + 60, 0);   // last buffer, byte 12, len 10
        check("R4", "len literal", int'(out_run_len), 10);
        run_one("R4", 1, 70, 2048 + 63, 0);   // byte 15 beyond per-buffer 16? idx3 byte15
        run_one("R4", 1, 70, 2048 + 69, 0);   // last byte, len 1
        run_one("R4", 2, 218, 4096 + 200, 0);
    endtask

    task automatic t_spare_only();
        run_one("R6", 0, 16, 5, 1);
        check("R6", "addr literal", int'(out_addr), 'h1005);
        run_one("R6", 1, 64, 40, 1);
    endtask

    task automatic t_words();
        run_one("R7", 2, 218, 10, 0);
        check("R7", "spare words", int'(out_spare_words), 109);
        run_one("R7", 1, 65, 10, 0);
        check("R7", "spare words odd", int'(out_spare_words), 32);
    endtask

    task automatic t_errors();
        run_one("R8", 3, 64, 10, 0);          // unsupported page code
        run_one("R8", 2, 6, 10, 0);           // zero per-buffer count
        run_one("R8", 0, 100, 10, 0);         // last buffer over 64
        run_one("R8", 1, 64, 2048 + 64, 0);   // past spare end
        run_one("R8", 0, 16, 16, 1);          // spare-only past end
    endtask

    task automatic t_hold_and_strobe();
        int a0, l0;
        run_one("R9", 1, 64, 2048 + 20, 0);
        a0 = int'(out_addr); l0 = int'(out_run_len);
        in_page_sel = 2'd0; in_column = 13'd3; in_spare_bytes = 9'd16;
        @(negedge clk);
        check("R1", "strobe drops", int'(out_valid), 0);
        check("R9", "addr held", int'(out_addr), a0);
        check("R9", "len held",  int'(out_run_len), l0);
        check("R9", "words held", int'(out_spare_words), 32);
    endtask

    initial begin
        rst = 1; in_valid = 0; in_page_sel = 0; in_spare_bytes = 0;
        in_column = 0; in_spare_only = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_main();
        t_chunking();
        t_leftover();
        t_spare_only();
        t_words();
        t_errors();
        t_hold_and_strobe();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule